// File: doc/BRIEF.md
# Receive Output Formatter with Automatic Coder Mode

This block sits on the system side of a T1 line interface. It takes recovered positive and negative rail data together with the recovered clock, and it presents the receive data registered on a chosen recovered-clock edge. All logic runs on one fast core clock. The recovered clock and the transmit clock arrive as sampled levels, and the block finds their edges by comparing each with its value in the previous core cycle.

By default the block passes dual-rail data straight through. If the transmit negative-rail input stays high for more than sixteen transmit clocks, the block switches to coder operation. In coder operation the receive data output carries single-rail data and the receive negative output carries a bipolar-violation flag. When the mode input toggles once in every recovered-clock period, B8ZS substitutions are recognised and removed as well. A host/hardware select and an edge-select input decide which recovered-clock edge is the bit strobe.

Top module: `rxc_rx_iface`

## Requirements
- R1: With `host_mode_i` low, outputs change only on a rising recovered-clock edge, whatever `edge_sel_i` is. In dual-rail operation `rx_data_o`/`rx_neg_o` show the positive/negative rail sampled at that edge, one core clock after the edge is seen.
- R2: With `host_mode_i` high, the strobe is the falling recovered-clock edge when `edge_sel_i` is 1 and the rising edge when it is 0.
- R3: `coder_o` rises one core clock after the 17th consecutive rising transmit-clock edge that finds `tneg_i` high. After 16 such edges it is still low.
- R4: A rising transmit-clock edge that finds `tneg_i` low clears `coder_o` and restarts the count.
- R5: In coder operation `rx_data_o` is 1 for a mark (either rail high) and 0 for a space. `rx_neg_o` is the violation flag. Both belong to the bit sampled 8 strobes earlier, and each lasts exactly one bit.
- R6: A violation is a mark whose polarity (positive rail = positive) equals the polarity of the previous mark. The polarity before the first mark after reset counts as negative. A flagged bit always carries a mark.
- R7: `b8zs_o` goes high at the 8th consecutive recovered-clock rising edge whose period contained a rising edge of `mode_i`. It goes low at the first rising edge whose period had none.
- R8: With coder operation and `b8zs_o` high, eight bits forming 0,0,0,V,B,0,V,B (V a violation, B a correct mark) come out as eight spaces with no flag.
- R9: With `b8zs_o` low, that same pattern is not substituted: its marks appear on `rx_data_o` and both violations are flagged.
- R10: After reset `rx_data_o`, `rx_neg_o`, `coder_o` and `b8zs_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rclk_i | input | 1 | Recovered clock level |
| rx_pos_i | input | 1 | Recovered positive-rail data |
| rx_neg_i | input | 1 | Recovered negative-rail data |
| tclk_i | input | 1 | Transmit clock level |
| tneg_i | input | 1 | Transmit negative-rail input |
| host_mode_i | input | 1 | 1 = host operation, 0 = hardware operation |
| edge_sel_i | input | 1 | Strobe edge select in host operation |
| mode_i | input | 1 | Mode input; toggling with the recovered clock enables B8ZS |
| rx_data_o | output | 1 | Positive rail, or single-rail data in coder operation |
| rx_neg_o | output | 1 | Negative rail, or violation flag in coder operation |
| coder_o | output | 1 | Coder operation active |
| b8zs_o | output | 1 | B8ZS substitution decoding active |

## Verification
A dual-rail result is due one core clock after its strobe edge. The bench samples once in the middle of each bit, where only a rising-edge strobe has taken effect, and once at the end of the bit, after either edge. A coder result belongs to the bit sent eight strobes earlier, so the bench model keeps a bit history and compares each output with the entry eight places back. `coder_o` is read one core clock after each transmit-clock edge, and `b8zs_o` at the end of the bit that holds the 8th qualifying period. Mode changes happen only during runs of spaces, so no check depends on when the enable switches within a bit.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
    localparam int SUB_LEN = 8;

    typedef struct packed {
        logic mark;
        logic viol;
    } bit_ent_t;
endpackage

// File: rtl/rxc_coder_det.sv
module rxc_coder_det #(
    parameter int RUN_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tclk_rise_i,
    input  logic tneg_i,
    output logic coder_o
);
    localparam int CW = $clog2(RUN_LEN + 2);
    localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          coder;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tclk_rise_i) begin
            if (tneg_i) begin
                st_d.cnt   = (st_q.cnt == LIMIT) ? LIMIT : st_q.cnt + 1'b1;
                st_d.coder = (st_d.cnt == LIMIT);
            end else begin
                st_d.cnt   = '0;
                st_d.coder = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign coder_o = st_q.coder;

    AST_CODER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (tclk_rise_i && !tneg_i) |=> !coder_o); // R4
    AST_CODER_ENTRY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coder_o) |-> $past(tclk_rise_i && tneg_i)); // R3
endmodule

// File: rtl/rxc_tie_det.sv
module rxc_tie_det #(
    parameter int PERIODS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rclk_rise_i,
    input  logic mode_i,
    output logic tied_o
);
    localparam int CW = $clog2(PERIODS + 1);
    localparam logic [CW-1:0] CMAX = CW'(PERIODS);

    typedef struct packed {
        logic          mode;
        logic          seen;
        logic [CW-1:0] cnt;
    } st_t;

    st_t  st_d, st_q;
    logic mode_rise;

    assign mode_rise = mode_i & ~st_q.mode;

    always_comb begin
        st_d      = st_q;
        st_d.mode = mode_i;
        if (rclk_rise_i) begin
            if (st_q.seen || mode_rise)
                st_d.cnt = (st_q.cnt == CMAX) ? CMAX : st_q.cnt + 1'b1;
            else
                st_d.cnt = '0;
            st_d.seen = 1'b0;
        end else if (mode_rise) begin
            st_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tied_o = (st_q.cnt == CMAX);

    AST_TIE_ON_RCLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tied_o) |-> $past(rclk_rise_i)); // R7
    AST_TIE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rclk_rise_i && !st_q.seen && !(mode_i && !st_q.mode)) |=> !tied_o); // R7
endmodule

// File: rtl/rxc_b8zs_dec.sv
module rxc_b8zs_dec
    import rxc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic pos_i,
    input  logic neg_i,
    input  logic sub_en_i,
    output logic data_o,
    output logic bpv_o
);
    typedef struct packed {
        bit_ent_t [SUB_LEN-1:0] win;
        logic                   lp;
        logic                   data;
        logic                   bpv;
    } st_t;

    st_t  st_d, st_q;
    logic mark_in;

    function automatic logic is_sub(input bit_ent_t [SUB_LEN-1:0] w);
        return !w[0].mark && !w[1].mark && !w[2].mark &&
               w[3].mark &&  w[3].viol && w[4].mark && !w[4].viol &&
               !w[5].mark &&
               w[6].mark &&  w[6].viol && w[7].mark && !w[7].viol;
    endfunction

    assign mark_in = pos_i | neg_i;

    always_comb begin
        st_d = st_q;
        if (strobe_i) begin
            st_d.data = st_q.win[0].mark;
            st_d.bpv  = st_q.win[0].viol;
            for (int i = 0; i < SUB_LEN - 1; i++)
                st_d.win[i] = st_q.win[i+1];
            st_d.win[SUB_LEN-1].mark = mark_in;
            st_d.win[SUB_LEN-1].viol = mark_in && (pos_i == st_q.lp);
            if (mark_in) st_d.lp = pos_i;
            if (sub_en_i && is_sub(st_d.win)) st_d.win = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o = st_q.data;
    assign bpv_o  = st_q.bpv;

    AST_BPV_ON_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        bpv_o |-> data_o); // R6
    AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> $stable({data_o, bpv_o})); // R5
endmodule

// File: rtl/rxc_rx_iface.sv
module rxc_rx_iface #(
    parameter int CODER_RUN   = 16,
    parameter int TIE_PERIODS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rclk_i,
    input  logic rx_pos_i,
    input  logic rx_neg_i,
    input  logic tclk_i,
    input  logic tneg_i,
    input  logic host_mode_i,
    input  logic edge_sel_i,
    input  logic mode_i,
    output logic rx_data_o,
    output logic rx_neg_o,
    output logic coder_o,
    output logic b8zs_o
);
    typedef struct packed {
        logic rclk;
        logic tclk;
        logic pos;
        logic neg;
    } st_t;

    st_t  st_d, st_q;
    logic rclk_rise, rclk_fall, tclk_rise, strobe;
    logic dec_data, dec_bpv, coder, tied;

    assign rclk_rise = rclk_i & ~st_q.rclk;
    assign rclk_fall = ~rclk_i & st_q.rclk;
    assign tclk_rise = tclk_i & ~st_q.tclk;
    assign strobe    = (host_mode_i && edge_sel_i) ? rclk_fall : rclk_rise;

    always_comb begin
        st_d      = st_q;
        st_d.rclk = rclk_i;
        st_d.tclk = tclk_i;
        if (strobe) begin
            st_d.pos = rx_pos_i;
            st_d.neg = rx_neg_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rxc_coder_det #(.RUN_LEN(CODER_RUN)) i_coder (
        .clk        (clk),
        .rst_n      (rst_n),
        .tclk_rise_i(tclk_rise),
        .tneg_i     (tneg_i),
        .coder_o    (coder)
    );

    rxc_tie_det #(.PERIODS(TIE_PERIODS)) i_tie (
        .clk        (clk),
        .rst_n      (rst_n),
        .rclk_rise_i(rclk_rise),
        .mode_i     (mode_i),
        .tied_o     (tied)
    );

    rxc_b8zs_dec i_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe_i(strobe),
        .pos_i   (rx_pos_i),
        .neg_i   (rx_neg_i),
        .sub_en_i(coder & tied),
        .data_o  (dec_data),
        .bpv_o   (dec_bpv)
    );

    assign rx_data_o = coder ? dec_data : st_q.pos;
    assign rx_neg_o  = coder ? dec_bpv  : st_q.neg;
    assign coder_o   = coder;
    assign b8zs_o    = tied;

    AST_HW_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_mode_i && rclk_fall) |=> $stable({st_q.pos, st_q.neg})); // R1
    AST_HOST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode_i && edge_sel_i && rclk_rise) |=> $stable({st_q.pos, st_q.neg})); // R2
    AST_HOST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode_i && !edge_sel_i && rclk_fall) |=> $stable({st_q.pos, st_q.neg})); // R2
endmodule

// File: tb/test_rxc_rx_iface.sv
module test_rxc_rx_iface;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rclk = 0, rx_pos = 0, rx_neg = 0, tclk = 0, tneg = 0;
    logic host_mode = 0, edge_sel = 0, mode = 0;
    logic rx_data, rx_negd, coder, b8zs;

    always #5 clk = ~clk;

    rxc_rx_iface i_rxc_rx_iface (
        .clk(clk), .rst_n(rst_n), .rclk_i(rclk), .rx_pos_i(rx_pos), .rx_neg_i(rx_neg),
        .tclk_i(tclk), .tneg_i(tneg), .host_mode_i(host_mode), .edge_sel_i(edge_sel),
        .mode_i(mode), .rx_data_o(rx_data), .rx_neg_o(rx_negd), .coder_o(coder), .b8zs_o(b8zs)
    );

    int errors = 0;
    int checks = 0;
    bit hp[0:4095], hn[0:4095], hm[0:4095], hv[0:4095];
    int nbits = 0;
    bit m_lp = 0;
    bit exp_coder = 0, exp_b8 = 0, tie_on = 0;
    int tie_cnt = 0, run_cnt = 0;

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (bit %0d)", req, act, exp, nbits);
        end
    endtask

    function automatic bit is_pattern(int e);
        return !hm[e-7] && !hm[e-6] && !hm[e-5] && hm[e-4] && hv[e-4] &&
               hm[e-3] && !hv[e-3] && !hm[e-2] && hm[e-1] && hv[e-1] && hm[e] && !hv[e];
    endfunction

    task automatic send_bit(bit p, bit n, string req);
        bit rise_mode;
        bit prev_p, prev_n;
        int idx;
        rise_mode = !(host_mode && edge_sel);
        idx = nbits;
        prev_p = (idx > 0) ? hp[idx-1] : 1'b0;
        prev_n = (idx > 0) ? hn[idx-1] : 1'b0;
        @(negedge clk);
        rx_pos = p; rx_neg = n; rclk = 1'b1;
        if (tie_on) mode = 1'b1;
        @(negedge clk);
        if (!exp_coder) begin
            check_eq({req, " mid data"}, rx_data, rise_mode ? p : prev_p);
            check_eq({req, " mid neg"},  rx_negd, rise_mode ? n : prev_n);
        end
        @(negedge clk);
        rclk = 1'b0;
        if (tie_on) mode = 1'b0;
        @(negedge clk);
        hp[idx] = p; hn[idx] = n;
        hm[idx] = p | n;
        hv[idx] = (p | n) && (p == m_lp);
        if (p | n) m_lp = p;
        if (exp_b8 && exp_coder && idx >= 7 && is_pattern(idx))
            for (int k = idx - 7; k <= idx; k++) begin hm[k] = 0; hv[k] = 0; end
        nbits++;
        tie_cnt = tie_on ? ((tie_cnt < 8) ? tie_cnt + 1 : 8) : 0;
        exp_b8 = (tie_cnt == 8);
        if (exp_coder) begin
            check_eq({req, " coder data"}, rx_data, (idx >= 8) ? hm[idx-8] : 0);
            check_eq({req, " coder bpv"},  rx_negd, (idx >= 8) ? hv[idx-8] : 0);
        end else begin
            check_eq({req, " dual data"}, rx_data, p);
            check_eq({req, " dual neg"},  rx_negd, n);
        end
        check_eq("R7 b8zs state", b8zs, exp_b8);
    endtask

    task automatic tick_t(bit v);
        @(negedge clk);
        tneg = v; tclk = 1'b1;
        @(negedge clk);
        tclk = 1'b0;
        if (v) begin
            run_cnt = (run_cnt < 17) ? run_cnt + 1 : 17;
            exp_coder = (run_cnt == 17);
        end else begin
            run_cnt = 0;
            exp_coder = 0;
        end
    endtask

    task automatic dual_random(int cnt, string req);
        for (int i = 0; i < cnt; i++) begin
            int r;
            r = $urandom % 3;
            send_bit(r == 1, r == 2, req);
        end
    endtask

    task automatic send_pattern(string req);
        bit g;
        g = m_lp;
        send_bit(0, 0, req); send_bit(0, 0, req); send_bit(0, 0, req);
        send_bit(g, !g, req); send_bit(!g, g, req);
        send_bit(0, 0, req);
        send_bit(!g, g, req); send_bit(g, !g, req);
    endtask

    task automatic ami_stream(int cnt, string req);
        for (int i = 0; i < cnt; i++) begin
            int r;
            r = $urandom % 40;
            if (r < 3)       send_pattern(req);
            else if (r < 5)  send_bit(m_lp, !m_lp, req);
            else if (r < 22) send_bit(!m_lp, m_lp, req);
            else             send_bit(0, 0, req);
        end
    endtask

    initial begin
        #(10 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4321));
        repeat (3) @(negedge clk);
        check_eq("R10 reset data", rx_data, 0);
        check_eq("R10 reset neg", rx_negd, 0);
        check_eq("R10 reset coder", coder, 0);
        check_eq("R10 reset b8zs", b8zs, 0);
        rst_n = 1'b1;
        @(negedge clk);

        host_mode = 0; edge_sel = 0;
        dual_random(30, "R1");
        edge_sel = 1;
        dual_random(20, "R1 edge_sel ignored");
        host_mode = 1; edge_sel = 0;
        dual_random(20, "R2 rising");
        edge_sel = 1;
        dual_random(20, "R2 falling");
        host_mode = 0; edge_sel = 0;

        for (int i = 0; i < 16; i++) tick_t(1);
        check_eq("R3 after 16", coder, 0);
        tick_t(1);
        check_eq("R3 after 17", coder, 1);
        tick_t(0);
        check_eq("R4 exit", coder, 0);
        for (int i = 0; i < 10; i++) tick_t(1);
        tick_t(0);
        for (int i = 0; i < 16; i++) tick_t(1);
        check_eq("R4 restart count", coder, 0);
        tick_t(1);
        check_eq("R3 re-entry", coder, 1);

        for (int i = 0; i < 8; i++) send_bit(0, 0, "R5");
        ami_stream(150, "R5 R6 R9");
        send_pattern("R9 no substitution");
        for (int i = 0; i < 8; i++) send_bit(0, 0, "R5");

        tie_on = 1;
        for (int i = 0; i < 7; i++) send_bit(0, 0, "R7 building");
        check_eq("R7 after 7 periods", b8zs, 0);
        send_bit(0, 0, "R7");
        check_eq("R7 after 8 periods", b8zs, 1);
        for (int i = 0; i < 8; i++) send_bit(0, 0, "R8");
        send_pattern("R8 substitution");
        ami_stream(150, "R8 R6");
        host_mode = 1; edge_sel = 1;
        for (int i = 0; i < 8; i++) send_bit(0, 0, "R8");
        ami_stream(100, "R8 R2 falling");
        for (int i = 0; i < 8; i++) send_bit(0, 0, "R8");
        host_mode = 0; edge_sel = 0;

        tie_on = 0;
        send_bit(0, 0, "R7 drop");
        check_eq("R7 dropped", b8zs, 0);
        for (int i = 0; i < 8; i++) send_bit(0, 0, "R9");
        send_pattern("R9 after drop");
        for (int i = 0; i < 8; i++) send_bit(0, 0, "R9");

        tick_t(0);
        check_eq("R4 leave coder", coder, 0);
        dual_random(20, "R1 after coder");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule